// File: doc/BRIEF.md
# Self-Test Code Nibble Link and Hex Display

This block holds the 8-bit self-test code that the host writes while it boots, and shows that code as two hex digits. A transmit side and a receive side are joined by a 4-wire link. The transmit side sends the upper half of the code while a slow reference clock is high and the lower half while it is low, so one byte crosses the link in each reference period. The receive side takes the two halves back apart and turns each one into a seven-segment pattern covering 0 to F.

The reference clock, nominally 32 kHz, comes in as a level that is sampled in the fast system clock domain. Each side has its own edge detector and a two-state machine. Transmit states: TX_SEND_LO (drive the lower nibble; a rising reference edge goes to TX_SEND_HI and loads the shadow copy of the code) and TX_SEND_HI (drive the upper nibble; a falling edge goes back to TX_SEND_LO). Receive states: RX_WAIT_HI (a falling edge captures the link as the upper nibble and goes to RX_HAVE_HI) and RX_HAVE_HI (a rising edge takes the link as the lower nibble, updates both digits together and goes back to RX_WAIT_HI).

Top module: `post_disp_top`

## Requirements
- R1: A cycle with `wr_en` high loads `wr_data` into the code latch at that clock edge. When several writes come before a pair is sent, the last one is displayed.
- R2: After reset the code is 8'h00, both segment outputs read 7'h3F (digit "0") and the link reads 4'h0.
- R3: From the first clock after the reference clock is sampled rising, and for as long as it stays high, the link carries bits [7:4] of the code held in the latch just before that rise.
- R4: While the reference clock is low, from the first clock after it is sampled falling, the link carries bits [3:0] of that same snapshot.
- R5: The receiver captures the upper nibble at a falling reference edge. At the next rising edge it updates both digits in the same clock cycle, and they are visible one system clock after the rise is sampled.
- R6: The segment outputs do not change except at a rising reference edge that completes an upper-then-lower pair. A lower nibble that arrives with no upper nibble before it (the first rise after reset) leaves the display unchanged.
- R7: A write made during a pair does not tear that pair. The displayed byte is either wholly the old code or wholly the new one, and the new code appears at the end of the following pair.
- R8: Segments are active-high, bit 6..0 = g,f,e,d,c,b,a: 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F A=77 b=7C C=39 d=5E E=79 F=71.
- R9: `seg_hi_o` shows bits [7:4] of the displayed code and `seg_lo_o` shows bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the code latch |
| wr_data | input | 8 | Self-test code byte |
| ref_clk | input | 1 | Slow reference clock, sampled as a level |
| link_o | output | 4 | Nibble link between the transmit and receive sides |
| seg_hi_o | output | 7 | Segments of the upper digit, gfedcba |
| seg_lo_o | output | 7 | Segments of the lower digit, gfedcba |

## Verification
Four properties are checked on every cycle:
- a write lands in the latch;
- the upper nibble is on the link right after each rising reference edge;
- the segment outputs hold still on any cycle that is not a completed-pair edge;
- no digit ever goes fully dark.

Some behaviour can only be shown by the bench scenarios. These are the exact segment patterns for all sixteen values, the lower nibble on the link during the low phase, and the lone first rise after reset being ignored. The same applies to a write in the middle of a pair staying out of that pair, and to both digits switching on the same clock.

// File: rtl/post_disp_pkg.sv
package post_disp_pkg;
    typedef enum logic {TX_SEND_LO, TX_SEND_HI} tx_state_e;
    typedef enum logic {RX_WAIT_HI, RX_HAVE_HI} rx_state_e;
endpackage

// File: rtl/post_seg_dec.sv
// Hex nibble to seven-segment pattern, active-high, bit order gfedcba.
module post_seg_dec #(
    parameter int NIB_W = 4,
    parameter int SEG_W = 7
) (
    input  logic [NIB_W-1:0] nib_i,
    output logic [SEG_W-1:0] seg_o
);
    always_comb begin
        unique case (nib_i)
            4'h0: seg_o = 7'h3F;
            4'h1: seg_o = 7'h06;
            4'h2: seg_o = 7'h5B;
            4'h3: seg_o = 7'h4F;
            4'h4: seg_o = 7'h66;
            4'h5: seg_o = 7'h6D;
            4'h6: seg_o = 7'h7D;
            4'h7: seg_o = 7'h07;
            4'h8: seg_o = 7'h7F;
            4'h9: seg_o = 7'h6F;
            4'hA: seg_o = 7'h77;
            4'hB: seg_o = 7'h7C;
            4'hC: seg_o = 7'h39;
            4'hD: seg_o = 7'h5E;
            4'hE: seg_o = 7'h79;
            default: seg_o = 7'h71;
        endcase
    end
endmodule

// File: rtl/post_nib_tx.sv
// Transmit side: snapshots the code at each rising reference edge,
// drives the upper nibble in the high phase and the lower one in the low phase.
module post_nib_tx
    import post_disp_pkg::*;
#(
    parameter int CODE_W = 8,
    localparam int NIB_W = CODE_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic [CODE_W-1:0] code_i,
    output logic [NIB_W-1:0]  nib_o
);
    tx_state_e         state_q, state_d;
    logic              ref_q;
    logic [CODE_W-1:0] shadow_q;
    logic              ref_rise, ref_fall;

    assign ref_rise = ref_clk & ~ref_q;
    assign ref_fall = ~ref_clk & ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= TX_SEND_LO;
            ref_q    <= 1'b0;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            ref_q   <= ref_clk;
            if (ref_rise) shadow_q <= code_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_SEND_LO: if (ref_rise) state_d = TX_SEND_HI;
            TX_SEND_HI: if (ref_fall) state_d = TX_SEND_LO;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TX_SEND_HI: nib_o = shadow_q[CODE_W-1:NIB_W];
            TX_SEND_LO: nib_o = shadow_q[NIB_W-1:0];
        endcase
    end
endmodule

// File: rtl/post_nib_rx.sv
// Receive side: captures the upper nibble at a falling reference edge and
// commits the whole byte at the following rising edge.
module post_nib_rx
    import post_disp_pkg::*;
#(
    parameter int CODE_W = 8,
    localparam int NIB_W = CODE_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [CODE_W-1:0] code_o
);
    rx_state_e         state_q, state_d;
    logic              ref_q;
    logic [NIB_W-1:0]  hold_q;
    logic [CODE_W-1:0] shown_q;
    logic              ref_rise, ref_fall;

    assign ref_rise = ref_clk & ~ref_q;
    assign ref_fall = ~ref_clk & ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_WAIT_HI;
            ref_q   <= 1'b0;
            hold_q  <= '0;
            shown_q <= '0;
        end else begin
            state_q <= state_d;
            ref_q   <= ref_clk;
            if (state_q == RX_WAIT_HI && ref_fall) hold_q <= nib_i;
            if (state_q == RX_HAVE_HI && ref_rise) shown_q <= {hold_q, nib_i};
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_WAIT_HI: if (ref_fall) state_d = RX_HAVE_HI;
            RX_HAVE_HI: if (ref_rise) state_d = RX_WAIT_HI;
        endcase
    end

    assign code_o = shown_q;
endmodule

// File: rtl/post_disp_top.sv
module post_disp_top #(
    parameter int CODE_W = 8,
    parameter int SEG_W  = 7,
    localparam int NIB_W  = CODE_W / 2,
    localparam int DIGITS = CODE_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              ref_clk,
    output logic [NIB_W-1:0]  link_o,
    output logic [SEG_W-1:0]  seg_hi_o,
    output logic [SEG_W-1:0]  seg_lo_o
);
    logic [CODE_W-1:0]      code_q;
    logic [CODE_W-1:0]      shown;
    logic [SEG_W-1:0]       segs [DIGITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     code_q <= '0;
        else if (wr_en) code_q <= wr_data;
    end

    post_nib_tx #(.CODE_W(CODE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .code_i(code_q), .nib_o(link_o)
    );

    post_nib_rx #(.CODE_W(CODE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .nib_i(link_o), .code_o(shown)
    );

    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
        post_seg_dec #(.NIB_W(NIB_W), .SEG_W(SEG_W)) u_dec (
            .nib_i(shown[d*NIB_W +: NIB_W]),
            .seg_o(segs[d])
        );
    end

    assign seg_lo_o = segs[0];
    assign seg_hi_o = segs[DIGITS-1];
endmodule

// File: rtl/post_disp_chk.sv
module post_disp_chk #(
    parameter int CODE_W = 8,
    parameter int SEG_W  = 7,
    localparam int NIB_W = CODE_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_data,
    input logic              ref_clk,
    input logic [NIB_W-1:0]  link_o,
    input logic [SEG_W-1:0]  seg_hi_o,
    input logic [SEG_W-1:0]  seg_lo_o,
    input logic [CODE_W-1:0] code_q
);
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> code_q == $past(wr_data)); // R1

    AST_LINK_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_clk) |=> link_o == $past(code_q[CODE_W-1:NIB_W])); // R3

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ref_clk) |=> ($stable(seg_hi_o) && $stable(seg_lo_o))); // R6

    AST_SEG_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_hi_o != '0) && (seg_lo_o != '0)); // R8
endmodule

bind post_disp_top post_disp_chk #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ref_clk(ref_clk), .link_o(link_o), .seg_hi_o(seg_hi_o),
    .seg_lo_o(seg_lo_o), .code_q(code_q)
);

// File: tb/post_disp_top_tb_top.sv
`timescale 1ns/1ps
module post_disp_top_tb_top;
    localparam int HALF = 6;
    localparam int NVEC = 8;
    localparam logic [7:0] VEC_CODE [NVEC] = '{8'h01, 8'h23, 8'h45, 8'h67,
                                              8'h89, 8'hAB, 8'hCD, 8'hEF};
    localparam logic [13:0] VEC_SEG [NVEC] = '{
        {7'h3F, 7'h06}, {7'h5B, 7'h4F}, {7'h66, 7'h6D}, {7'h7D, 7'h07},
        {7'h7F, 7'h6F}, {7'h77, 7'h7C}, {7'h39, 7'h5E}, {7'h79, 7'h71}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ref_clk = 1'b0;
    logic [3:0] link_o;
    logic [6:0] seg_hi_o, seg_lo_o;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    post_disp_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ref_clk(ref_clk), .link_o(link_o), .seg_hi_o(seg_hi_o), .seg_lo_o(seg_lo_o)
    );

    function automatic logic [6:0] seg_of(input logic [3:0] n);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[n];
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v; cyc(1); wr_en = 1'b0;
    endtask

    task automatic ref_hi();
        ref_clk = 1'b1; cyc(HALF);
    endtask

    task automatic ref_lo();
        ref_clk = 1'b0; cyc(HALF);
    endtask

    task automatic chk_disp(input string req, input logic [7:0] c);
        chk(req, {seg_hi_o, seg_lo_o}, {seg_of(c[7:4]), seg_of(c[3:0])});
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R2 reset state
        chk("R2 seg_hi", seg_hi_o, 7'h3F);
        chk("R2 seg_lo", seg_lo_o, 7'h3F);
        chk("R2 link", link_o, 4'h0);

        // R6: first rise and a captured upper nibble alone change nothing
        host_write(8'h5A);
        ref_hi();
        ref_lo();
        chk_disp("R6 lone half", 8'h00);

        // table walk: R3 R4 R5 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            host_write(VEC_CODE[i]);
            ref_hi();
            chk("R3 link upper", link_o, VEC_CODE[i][7:4]);
            ref_lo();
            chk("R4 link lower", link_o, VEC_CODE[i][3:0]);
            ref_hi();
            ref_lo();
            chk("R8 table", {seg_hi_o, seg_lo_o}, VEC_SEG[i]);
            chk("R9 digit order", seg_hi_o, seg_of(VEC_CODE[i][7:4]));
        end

        // R5: both digits change on the same clock after the completing rise
        host_write(8'h3C);
        ref_hi();
        ref_lo();
        ref_clk = 1'b1;
        chk_disp("R5 before commit", VEC_CODE[NVEC-1]);
        cyc(1);
        chk_disp("R5 after commit", 8'h3C);
        cyc(HALF - 1);
        ref_lo();

        // R1: last of several writes wins
        host_write(8'h11);
        host_write(8'h22);
        host_write(8'h9E);
        ref_hi(); ref_lo(); ref_hi(); ref_lo();
        chk_disp("R1 last write", 8'h9E);

        // R7: write in mid-pair stays out of that pair
        host_write(8'hD4);
        ref_hi();
        host_write(8'h7B);
        ref_lo();
        ref_hi();
        chk_disp("R7 old pair whole", 8'hD4);
        ref_lo();
        ref_hi();
        chk_disp("R7 new pair", 8'h7B);
        ref_lo();

        // R6: no reference activity, display holds despite writes
        host_write(8'h00);
        cyc(20);
        chk_disp("R6 hold", 8'h7B);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule